// File: doc/BRIEF.md
# USB-C Source Attach and Fault Sequencer

This block is the control sequencer of a USB Type-C power source. It watches debounced CC comparator levels for a Sink, qualifies the attach over a fixed number of millisecond ticks, then switches on the external DC-DC converter and, later, the USB 2.0 data switch. The converter is switched on only when VBUS was at ground at the moment the attach was qualified.

Seven fault inputs come from analog comparators: VBUS over-voltage, VBUS under-voltage, over-current, external over-temperature, internal over-temperature, CC over-voltage and D+/D- over-voltage. Each has its own tick-counted debounce. A qualified fault drops the supply and data-switch enables, removes the CC pull-ups and turns the VBUS discharge on. Once every fault has cleared, a restart wait runs. This wait is long in normal use and short when a debug accessory is flagged. When it ends, the pull-ups return and a new attach may start.

All timing is counted on a 1 ms tick input, so the tick rate sets the time scale.

Top module: `src_prot_seq`

## Requirements
- R1: After reset, dc_en=0, don=0, disc_en=1 and cc_pu_en=1.
- R2: An attach is qualified only after cc_rd has stayed high for ATTACH_TICKS ticks in a row. If cc_rd drops before that, the block returns to idle, and the next attempt counts from zero.
- R3: dc_en rises SUPPLY_TICKS ticks after the attach is qualified. If vbus_present is high when the attach is qualified, dc_en and don stay low (with cc_pu_en high) until detach.
- R4: don rises DATA_TICKS ticks after the attach is qualified. It stays high until detach or a fault.
- R5: A qualified fault drives dc_en, don and cc_pu_en low and disc_en high on the next clock edge.
- R6: Each fault input is qualified only after it has stayed high for its own tick count (OVP_TICKS, UVP_TICKS, OCP_TICKS, EOTP_TICKS, IOTP_TICKS, CCOVP_TICKS, DOVP_TICKS). If the input drops before that, its count restarts from zero.
- R7: The over-current input counts only while dc_en=1 and pps_mode=0; with pps_mode=1 it never causes a fault. The under-voltage input counts only while dc_en=1.
- R8: Once all faults have cleared, cc_pu_en stays low and disc_en high for RESTART_TICKS ticks (DBG_RESTART_TICKS when dbg_acc=1). After that the block is idle with cc_pu_en=1.
- R9: A fault qualified during the restart wait returns the block to the fault state. The full wait then runs again after that fault clears.
- R10: cc_open high while attached drives dc_en and don low and disc_en high on the next clock edge, and returns the block to idle.
- R11: Attach, enable, fault and restart counts advance only in cycles with tick=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle 1 ms time base strobe |
| cc_rd | input | 1 | CC voltage is inside the Sink-present window |
| cc_open | input | 1 | CC voltage is above the disconnect threshold |
| vbus_present | input | 1 | VBUS is above ground level |
| pps_mode | input | 1 | Programmable-supply contract is active (current is regulated) |
| dbg_acc | input | 1 | Debug accessory was detected |
| flt_ovp | input | 1 | Raw VBUS over-voltage comparator |
| flt_uvp | input | 1 | Raw VBUS under-voltage comparator |
| flt_ocp | input | 1 | Raw over-current comparator |
| flt_eotp | input | 1 | Raw external over-temperature comparator |
| flt_iotp | input | 1 | Raw internal over-temperature comparator |
| flt_ccovp | input | 1 | Raw CC line over-voltage comparator |
| flt_dovp | input | 1 | Raw D+/D- over-voltage comparator |
| dc_en | output | 1 | Enable to the external DC-DC converter |
| don | output | 1 | Enable to the USB 2.0 data switch |
| disc_en | output | 1 | VBUS discharge enable |
| cc_pu_en | output | 1 | CC pull-up current enable |

## Verification
With tick held high, an input changed just before edge 1 shows its effect after a fixed count of edges. dc_en rises after ATTACH_TICKS+SUPPLY_TICKS+1 edges and don after ATTACH_TICKS+DATA_TICKS+1. A fault input with debounce N drops dc_en after N+1 edges. cc_pu_en returns 2+wait edges after the fault inputs clear, and a detach takes effect after one edge. The bench samples on the falling edge both one edge before and exactly at each of these points, so an off-by-one in any counter fails a check. Random fault pulses are scored by a bench function that compares the pulse length with the debounce length.

// File: rtl/src_prot_seq.sv
module src_prot_seq #(
  parameter int ATTACH_TICKS      = 150,
  parameter int SUPPLY_TICKS      = 100,
  parameter int DATA_TICKS        = 900,
  parameter int RESTART_TICKS     = 2000,
  parameter int DBG_RESTART_TICKS = 100,
  parameter int OVP_TICKS         = 75,
  parameter int UVP_TICKS         = 60,
  parameter int OCP_TICKS         = 60,
  parameter int EOTP_TICKS        = 90,
  parameter int IOTP_TICKS        = 1,
  parameter int CCOVP_TICKS       = 1,
  parameter int DOVP_TICKS        = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic cc_rd,
  input  logic cc_open,
  input  logic vbus_present,
  input  logic pps_mode,
  input  logic dbg_acc,
  input  logic flt_ovp,
  input  logic flt_uvp,
  input  logic flt_ocp,
  input  logic flt_eotp,
  input  logic flt_iotp,
  input  logic flt_ccovp,
  input  logic flt_dovp,
  output logic dc_en,
  output logic don,
  output logic disc_en,
  output logic cc_pu_en
);

  function automatic int big(int a, int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int db_len(int i);
    case (i)
      0: return OVP_TICKS;
      1: return UVP_TICKS;
      2: return OCP_TICKS;
      3: return EOTP_TICKS;
      4: return IOTP_TICKS;
      5: return CCOVP_TICKS;
      default: return DOVP_TICKS;
    endcase
  endfunction

  localparam int NFLT = 7;
  localparam int TMAX = big(big(big(ATTACH_TICKS, DATA_TICKS), big(RESTART_TICKS, DBG_RESTART_TICKS)),
                            big(big(big(OVP_TICKS, UVP_TICKS), big(OCP_TICKS, EOTP_TICKS)),
                                big(big(IOTP_TICKS, CCOVP_TICKS), DOVP_TICKS)));
  localparam int TW = $clog2(TMAX + 1);

  typedef enum logic [2:0] {S_IDLE, S_DEB, S_WAIT, S_ON, S_HOLD, S_FLT, S_RST} st_t;

  st_t            st;
  logic [TW-1:0]  tcnt;
  logic           don_q;
  logic [NFLT-1:0] raw, fdb;
  logic           flt_any;
  logic [TW-1:0]  lim;

  assign dc_en    = (st == S_ON);
  assign don      = don_q;
  assign disc_en  = (st == S_IDLE) || (st == S_DEB) || (st == S_FLT) || (st == S_RST);
  assign cc_pu_en = !((st == S_FLT) || (st == S_RST));

  assign raw = {flt_dovp, flt_ccovp, flt_iotp, flt_eotp,
                flt_ocp & dc_en & !pps_mode, flt_uvp & dc_en, flt_ovp};
  assign flt_any = |fdb;
  assign lim = dbg_acc ? TW'(DBG_RESTART_TICKS - 1) : TW'(RESTART_TICKS - 1);

  for (genvar i = 0; i < NFLT; i++) begin : g_db
    logic [TW-1:0] c;
    logic          f;
    always_ff @(posedge clk) begin
      if (!rst_n || !raw[i]) begin
        c <= '0;
        f <= 1'b0;
      end else if (tick && !f) begin
        if (c == TW'(db_len(i) - 1)) f <= 1'b1;
        else c <= c + 1'b1;
      end
    end
    assign fdb[i] = f;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      tcnt  <= '0;
      don_q <= 1'b0;
    end else if (flt_any && st != S_FLT) begin
      st    <= S_FLT;
      tcnt  <= '0;
      don_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (cc_rd) begin
          st   <= S_DEB;
          tcnt <= '0;
        end
        S_DEB: begin
          if (!cc_rd) st <= S_IDLE;
          else if (tick) begin
            if (tcnt == TW'(ATTACH_TICKS - 1)) begin
              st   <= vbus_present ? S_HOLD : S_WAIT;
              tcnt <= '0;
            end else tcnt <= tcnt + 1'b1;
          end
        end
        S_WAIT: begin
          if (cc_open) st <= S_IDLE;
          else if (tick) begin
            tcnt <= tcnt + 1'b1;
            if (tcnt == TW'(SUPPLY_TICKS - 1)) st <= S_ON;
          end
        end
        S_ON: begin
          if (cc_open) begin
            st    <= S_IDLE;
            don_q <= 1'b0;
          end else if (tick && !don_q) begin
            tcnt <= tcnt + 1'b1;
            if (tcnt == TW'(DATA_TICKS - 1)) don_q <= 1'b1;
          end
        end
        S_HOLD: if (cc_open) st <= S_IDLE;
        S_FLT: if (!flt_any) begin
          st   <= S_RST;
          tcnt <= '0;
        end
        S_RST: if (tick) begin
          if (tcnt == lim) st <= S_IDLE;
          else tcnt <= tcnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

module src_prot_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic cc_open,
  input logic dc_en,
  input logic don,
  input logic disc_en,
  input logic cc_pu_en
);

  p_don_needs_supply_r4: assert property (@(posedge clk) disable iff (!rst_n)
    don |-> dc_en);

  p_fault_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cc_pu_en |-> (!dc_en && !don && disc_en));

  p_supply_no_discharge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dc_en |-> !disc_en);

  p_detach_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (dc_en && cc_open) |=> (!dc_en && !don && disc_en));

  p_pullup_return_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cc_pu_en) |-> (disc_en && !dc_en));

  p_don_falls_with_supply_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(don) |-> !dc_en);

endmodule

bind src_prot_seq src_prot_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cc_open(cc_open), .dc_en(dc_en),
  .don(don), .disc_en(disc_en), .cc_pu_en(cc_pu_en)
);

// File: tb/sim_src_prot_seq.sv
module sim_src_prot_seq;
  localparam int ATT = 6, SUP = 4, DAT = 10, RST = 20, DBG = 5;
  localparam int OVP = 7, UVP = 6, OCP = 6, EOTP = 9, IOTP = 2, CCOVP = 2, DOVP = 3;

  logic clk = 0, rst_n = 0, tick = 1;
  logic cc_rd = 0, cc_open = 0, vbus_present = 0, pps_mode = 0, dbg_acc = 0;
  logic flt_ovp = 0, flt_uvp = 0, flt_ocp = 0, flt_eotp = 0, flt_iotp = 0, flt_ccovp = 0, flt_dovp = 0;
  logic dc_en, don, disc_en, cc_pu_en;
  int total = 0, fails = 0;

  always #5 clk = ~clk;

  src_prot_seq #(
    .ATTACH_TICKS(ATT), .SUPPLY_TICKS(SUP), .DATA_TICKS(DAT), .RESTART_TICKS(RST),
    .DBG_RESTART_TICKS(DBG), .OVP_TICKS(OVP), .UVP_TICKS(UVP), .OCP_TICKS(OCP),
    .EOTP_TICKS(EOTP), .IOTP_TICKS(IOTP), .CCOVP_TICKS(CCOVP), .DOVP_TICKS(DOVP)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cc_rd(cc_rd), .cc_open(cc_open),
    .vbus_present(vbus_present), .pps_mode(pps_mode), .dbg_acc(dbg_acc),
    .flt_ovp(flt_ovp), .flt_uvp(flt_uvp), .flt_ocp(flt_ocp), .flt_eotp(flt_eotp),
    .flt_iotp(flt_iotp), .flt_ccovp(flt_ccovp), .flt_dovp(flt_dovp),
    .dc_en(dc_en), .don(don), .disc_en(disc_en), .cc_pu_en(cc_pu_en)
  );

  function automatic bit fault_due(int len, int db);
    return len >= db;
  endfunction

  function automatic int restart_len(bit dbg);
    return dbg ? DBG : RST;
  endfunction

  task automatic step(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic bring_up();
    cc_rd = 1;
    step(ATT + SUP);
    chk("R3 supply still off", dc_en, 1'b0);
    step(1);
    chk("R3 supply on", dc_en, 1'b1);
    step(DAT - SUP - 1);
    chk("R4 switch still off", don, 1'b0);
    step(1);
    chk("R4 switch on", don, 1'b1);
  endtask

  task automatic detach();
    cc_rd = 0;
    cc_open = 1;
    step(1);
    chk("R10 supply off", dc_en, 1'b0);
    chk("R10 switch off", don, 1'b0);
    chk("R10 discharge", disc_en, 1'b1);
    cc_open = 0;
    step(1);
  endtask

  task automatic wait_restart(bit dbg);
    step(1 + restart_len(dbg));
    chk("R8 pull-up held off", cc_pu_en, 1'b0);
    chk("R8 discharge during wait", disc_en, 1'b1);
    step(1);
    chk("R8 pull-up back", cc_pu_en, 1'b1);
  endtask

  task automatic set_flt(int k, logic v);
    case (k)
      0: flt_ovp = v;
      1: flt_uvp = v;
      default: flt_eotp = v;
    endcase
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    void'($urandom(32'd20231));
    @(negedge clk);
    step(3);
    rst_n = 1;
    step(1);
    chk("R1 dc_en", dc_en, 1'b0);
    chk("R1 don", don, 1'b0);
    chk("R1 disc_en", disc_en, 1'b1);
    chk("R1 cc_pu_en", cc_pu_en, 1'b1);

    // R2: lapse during attach debounce
    cc_rd = 1;
    step(ATT - 1);
    cc_rd = 0;
    step(1);
    step(ATT + SUP + 2);
    chk("R2 lapse keeps supply off", dc_en, 1'b0);
    bring_up();
    detach();

    // R11: no counting without tick
    tick = 0;
    cc_rd = 1;
    step(50);
    chk("R11 no progress without tick", dc_en, 1'b0);
    tick = 1;
    step(ATT + SUP - 1);
    chk("R11 supply not yet", dc_en, 1'b0);
    step(1);
    chk("R11 supply on after ticks", dc_en, 1'b1);
    detach();

    // R3: VBUS already present
    vbus_present = 1;
    cc_rd = 1;
    step(ATT + DAT + 5);
    chk("R3 vbus present blocks supply", dc_en, 1'b0);
    chk("R3 vbus present blocks switch", don, 1'b0);
    chk("R3 pull-up stays", cc_pu_en, 1'b1);
    vbus_present = 0;
    detach();

    // R5, R6, R8: over-voltage fault and normal restart
    bring_up();
    flt_ovp = 1;
    step(OVP);
    chk("R6 before debounce", dc_en, 1'b1);
    step(1);
    chk("R5 supply off", dc_en, 1'b0);
    chk("R5 switch off", don, 1'b0);
    chk("R5 discharge on", disc_en, 1'b1);
    chk("R5 pull-up off", cc_pu_en, 1'b0);
    flt_ovp = 0;
    cc_rd = 0;
    wait_restart(1'b0);

    // R8: debug accessory restart
    dbg_acc = 1;
    bring_up();
    flt_eotp = 1;
    step(EOTP + 1);
    chk("R5 temp fault pull-up off", cc_pu_en, 1'b0);
    flt_eotp = 0;
    cc_rd = 0;
    wait_restart(1'b1);
    dbg_acc = 0;

    // R9: fault during restart wait
    bring_up();
    flt_ccovp = 1;
    step(CCOVP + 3);
    flt_ccovp = 0;
    cc_rd = 0;
    step(6);
    chk("R9 in restart wait", cc_pu_en, 1'b0);
    flt_ccovp = 1;
    step(CCOVP + 1);
    flt_ccovp = 0;
    step(1 + RST);
    chk("R9 timer restarted", cc_pu_en, 1'b0);
    step(1);
    chk("R9 pull-up back", cc_pu_en, 1'b1);

    // R7: over-current ignored under programmable contract
    bring_up();
    pps_mode = 1;
    flt_ocp = 1;
    step(OCP + 10);
    chk("R7 ocp ignored in pps", dc_en, 1'b1);
    pps_mode = 0;
    step(OCP);
    chk("R7 ocp counting", dc_en, 1'b1);
    step(1);
    chk("R7 ocp fault fixed contract", dc_en, 1'b0);
    flt_ocp = 0;
    cc_rd = 0;
    wait_restart(1'b0);

    // R7: under-voltage ignored while supply off
    flt_uvp = 1;
    step(UVP + 10);
    chk("R7 uvp ignored while idle", cc_pu_en, 1'b1);
    flt_uvp = 0;
    step(1);

    // R6: random pulse lengths
    for (int it = 0; it < 18; it++) begin
      int k, db, len;
      bit due;
      k = $urandom_range(0, 2);
      db = (k == 0) ? OVP : (k == 1) ? UVP : EOTP;
      len = $urandom_range(1, db + 2);
      due = fault_due(len, db);
      bring_up();
      set_flt(k, 1'b1);
      step(len);
      set_flt(k, 1'b0);
      step(2);
      chk("R6 random pulse", dc_en, !due);
      if (due) begin
        cc_rd = 0;
        step(RST + 3);
      end else detach();
    end

    // R6: split pulses restart the count
    for (int it = 0; it < 6; it++) begin
      int l1, l2;
      l1 = $urandom_range(1, OVP - 1);
      l2 = $urandom_range(1, OVP - 1);
      bring_up();
      flt_ovp = 1;
      step(l1);
      flt_ovp = 0;
      step(1);
      flt_ovp = 1;
      step(l2);
      flt_ovp = 0;
      step(2);
      chk("R6 split pulse no fault", dc_en, 1'b1);
      detach();
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule